// File: doc/BRIEF.md
# Periodic Conversion Frame Timer

This block sets a fixed, software-free conversion rate for an external serial ADC. A free-running period counter, clocked by the fast system clock, splits time into frames of `PERIOD` cycles (2250 cycles by default, which gives 48 kHz from a 108 MHz clock). Two compare points on that one counter shape every frame. The first drives the converter's active-low chip-select. The second fires a single-cycle trigger that launches a separate serial-clock burst generator.

Chip-select is inactive (high) for the opening counts of each frame. It goes active at `CS_CMP` and stays active until the frame ends. Each activation starts one conversion. The burst trigger fires at `TRIG_CMP`, which is later in the same frame, so the serial clock always starts at a fixed offset inside the active chip-select window. A one-cycle frame-start strobe marks count 0 of each frame. A downstream deserialiser or sample buffer can align to it.

An enable input starts and stops the whole sequence. While enable is low the counter is held at 0, chip-select is inactive and no pulses appear. When enable rises, a new frame begins at once.

Top module: `conv_frame_timer`

## Requirements
- R1: While running, the counter steps through 0 to PERIOD-1 and then wraps. `frame_start` is high for exactly one cycle at count 0, so consecutive strobes are exactly PERIOD cycles apart.
- R2: While running, `adc_cs_n` is 1 for counts below CS_CMP and 0 from CS_CMP up to and including PERIOD-1.
- R3: `burst_trig` is high for exactly one cycle per frame, at count TRIG_CMP, and is low at every other count.
- R4: In the first clock cycle after an edge where `enable` is 0, the outputs are `adc_cs_n`=1, `burst_trig`=0 and `frame_start`=0. They stay that way until `enable` returns.
- R5: On the first edge where `enable` is 1 after a stop (or after reset), the counter starts at count 0. `frame_start` is high in the cycle that follows that edge.
- R6: During and directly after reset, `adc_cs_n`=1, `burst_trig`=0 and `frame_start`=0.
- R7: `burst_trig` fires while `adc_cs_n` is 0, exactly TRIG_CMP-CS_CMP cycles after `adc_cs_n` falls in the same frame.
- R8: With CS_CMP=0, `adc_cs_n` is 0 at every count of every running frame, including count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run (1) or hold idle (0), sampled on rising clock edges |
| adc_cs_n | output | 1 | Active-low chip-select to the converter |
| burst_trig | output | 1 | One-cycle start pulse for the serial-clock burst generator |
| frame_start | output | 1 | One-cycle strobe at count 0 of each frame |

## Verification
The properties assume that `enable` is synchronous to `clk` and changes only between rising edges. They also assume the parameters keep 0 ≤ CS_CMP ≤ TRIG_CMP < PERIOD with PERIOD ≥ 2; elaboration checks reject any other setting. The frame-length property only holds across frames within one uninterrupted run, so the checker clears its history whenever `enable` drops. The stimulus drives `enable` only on falling clock edges. It stops the timer mid-frame while chip-select is active and restarts it, and it uses a second instance with chip-select at count 0 and the trigger on the last count, so the boundary settings stay within what the properties expect.

// File: rtl/cft_pkg.sv
package cft_pkg;

   // Variant of a compare channel: active from the compare point to the
   // end of the frame, or active on the compare point alone.
   typedef enum logic {
      CH_LEVEL = 1'b0,
      CH_PULSE = 1'b1
   } chan_mode_e;

   // Counter width needed to hold 0 .. period-1.
   function automatic int cnt_width(input int period);
      return (period <= 2) ? 1 : $clog2(period);
   endfunction

endpackage

// File: rtl/cft_period_counter.sv
module cft_period_counter #(
   parameter int PERIOD = 2250,
   parameter int W      = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   output logic [W-1:0] cnt_nxt,
   output logic         run_nxt
);

   localparam logic [W-1:0] LAST = W'(PERIOD - 1);

   logic [W-1:0] cnt_q;
   logic         run_q;

   // Next count: held at 0 while stopped, restarts at 0 on the first
   // running cycle, otherwise steps and wraps at the end of the frame.
   always_comb begin
      if (!enable || !run_q) begin
         cnt_nxt = '0;
      end else if (cnt_q == LAST) begin
         cnt_nxt = '0;
      end else begin
         cnt_nxt = cnt_q + 1'b1;
      end
   end

   assign run_nxt = enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         run_q <= run_nxt;
      end
   end

endmodule

// File: rtl/cft_cmp_chan.sv
module cft_cmp_chan
   import cft_pkg::*;
#(
   parameter int         W          = 12,
   parameter int         CMP        = 0,
   parameter chan_mode_e MODE       = CH_PULSE,
   parameter bit         ACTIVE_LOW = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_nxt,
   input  logic [W-1:0] cnt_nxt,
   output logic         q
);

   logic hit;
   logic act;

   generate
      if (MODE == CH_LEVEL) begin : g_level
         if (CMP == 0) begin : g_whole
            assign hit = 1'b1;
         end else begin : g_tail
            assign hit = (cnt_nxt >= W'(CMP));
         end
      end else begin : g_pulse
         assign hit = (cnt_nxt == W'(CMP));
      end
   endgenerate

   assign act = run_nxt & hit;

   // Registered so that the output pin never glitches on counter carries.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= ACTIVE_LOW;
      end else begin
         q <= act ^ ACTIVE_LOW;
      end
   end

endmodule

// File: rtl/conv_frame_timer.sv
module conv_frame_timer
   import cft_pkg::*;
#(
   parameter int PERIOD   = 2250,
   parameter int CS_CMP   = 225,
   parameter int TRIG_CMP = 725
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   output logic adc_cs_n,
   output logic burst_trig,
   output logic frame_start
);

   localparam int CNT_W = cnt_width(PERIOD);

   // Elaboration-time parameter checks.
   if (PERIOD < 2) begin : g_bad_period
      $error("conv_frame_timer: PERIOD must be at least 2");
   end
   if (CS_CMP < 0 || CS_CMP >= PERIOD) begin : g_bad_cs
      $error("conv_frame_timer: CS_CMP must lie inside the frame");
   end
   if (TRIG_CMP < CS_CMP || TRIG_CMP >= PERIOD) begin : g_bad_trig
      $error("conv_frame_timer: TRIG_CMP must lie in the active chip-select window");
   end

   logic [CNT_W-1:0] cnt_nxt;
   logic             run_nxt;

   cft_period_counter #(
      .PERIOD (PERIOD),
      .W      (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .cnt_nxt (cnt_nxt),
      .run_nxt (run_nxt)
   );

   cft_cmp_chan #(
      .W          (CNT_W),
      .CMP        (CS_CMP),
      .MODE       (CH_LEVEL),
      .ACTIVE_LOW (1'b1)
   ) u_cs (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_nxt (run_nxt),
      .cnt_nxt (cnt_nxt),
      .q       (adc_cs_n)
   );

   cft_cmp_chan #(
      .W          (CNT_W),
      .CMP        (TRIG_CMP),
      .MODE       (CH_PULSE),
      .ACTIVE_LOW (1'b0)
   ) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_nxt (run_nxt),
      .cnt_nxt (cnt_nxt),
      .q       (burst_trig)
   );

   cft_cmp_chan #(
      .W          (CNT_W),
      .CMP        (0),
      .MODE       (CH_PULSE),
      .ACTIVE_LOW (1'b0)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_nxt (run_nxt),
      .cnt_nxt (cnt_nxt),
      .q       (frame_start)
   );

endmodule

// File: rtl/cft_checker.sv
module cft_checker #(
   parameter int PERIOD   = 2250,
   parameter int CS_CMP   = 225,
   parameter int TRIG_CMP = 725
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic adc_cs_n,
   input logic burst_trig,
   input logic frame_start
);

   logic        prev_en;
   logic        seen;
   logic [31:0] since;

   // Cycles elapsed since the last frame strobe; equals the count inside a frame.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_en <= 1'b0;
         seen    <= 1'b0;
         since   <= '0;
      end else begin
         prev_en <= enable;
         if (!enable) begin
            seen <= 1'b0;
         end else if (frame_start) begin
            seen <= 1'b1;
         end
         if (frame_start) begin
            since <= 32'd1;
         end else if (since != '1) begin
            since <= since + 32'd1;
         end
      end
   end

   assert_frame_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   assert_frame_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && seen) |-> (since == 32'(PERIOD)));

   assert_cs_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> ((CS_CMP == 0) ? frame_start : (since == 32'(CS_CMP))));

   assert_cs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n) |-> (frame_start || !prev_en));

   assert_trig_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
      burst_trig |-> ((TRIG_CMP == 0) ? frame_start : (since == 32'(TRIG_CMP))));

   assert_trig_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      burst_trig |=> !burst_trig);

   assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (adc_cs_n && !burst_trig && !frame_start));

   assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !prev_en) |=> frame_start);

   assert_trig_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_trig |-> !adc_cs_n);

   always @(negedge rst_n) begin
      #0;
      assert_reset_R6: assert (adc_cs_n && !burst_trig && !frame_start);
   end

endmodule

bind conv_frame_timer cft_checker #(
   .PERIOD   (PERIOD),
   .CS_CMP   (CS_CMP),
   .TRIG_CMP (TRIG_CMP)
) u_cft_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .adc_cs_n    (adc_cs_n),
   .burst_trig  (burst_trig),
   .frame_start (frame_start)
);

// File: tb/conv_frame_timer_tb_top.sv
module frame_ref_model #(
   parameter int PERIOD = 2250,
   parameter int CS     = 225,
   parameter int TRIG   = 725
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   output logic e_cs_n,
   output logic e_trig,
   output logic e_frame
);
   int pos;
   bit live;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= 1'b0;
         pos  <= 0;
      end else if (!enable) begin
         live <= 1'b0;
         pos  <= 0;
      end else if (!live) begin
         live <= 1'b1;
         pos  <= 0;
      end else begin
         pos <= (pos + 1) % PERIOD;
      end
   end

   assign e_cs_n  = !(live && pos >= CS);
   assign e_trig  = live && (pos == TRIG);
   assign e_frame = live && (pos == 0);
endmodule

module conv_frame_timer_tb_top;

   localparam int A_PERIOD = 2250;
   localparam int A_CS     = 225;
   localparam int A_TRIG   = 725;
   localparam int B_PERIOD = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;

   logic a_cs_n, a_trig, a_frame;
   logic b_cs_n, b_trig, b_frame;
   logic ea_cs_n, ea_trig, ea_frame;
   logic eb_cs_n, eb_trig, eb_frame;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   conv_frame_timer dut_i (
      .clk (clk), .rst_n (rst_n), .enable (enable),
      .adc_cs_n (a_cs_n), .burst_trig (a_trig), .frame_start (a_frame)
   );

   conv_frame_timer #(.PERIOD (B_PERIOD), .CS_CMP (0), .TRIG_CMP (B_PERIOD - 1)) dut_b_i (
      .clk (clk), .rst_n (rst_n), .enable (enable),
      .adc_cs_n (b_cs_n), .burst_trig (b_trig), .frame_start (b_frame)
   );

   frame_ref_model #(.PERIOD (A_PERIOD), .CS (A_CS), .TRIG (A_TRIG)) ref_a (
      .clk (clk), .rst_n (rst_n), .enable (enable),
      .e_cs_n (ea_cs_n), .e_trig (ea_trig), .e_frame (ea_frame)
   );

   frame_ref_model #(.PERIOD (B_PERIOD), .CS (0), .TRIG (B_PERIOD - 1)) ref_b (
      .clk (clk), .rst_n (rst_n), .enable (enable),
      .e_cs_n (eb_cs_n), .e_trig (eb_trig), .e_frame (eb_frame)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the reference model.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 cs_n (A)",        int'(a_cs_n),  int'(ea_cs_n));
         chk("R3 trigger (A)",     int'(a_trig),  int'(ea_trig));
         chk("R1 frame strobe (A)", int'(a_frame), int'(ea_frame));
         chk("R8 cs_n (B)",        int'(b_cs_n),  int'(eb_cs_n));
         chk("R3 trigger (B)",     int'(b_trig),  int'(eb_trig));
         chk("R1 frame strobe (B)", int'(b_frame), int'(eb_frame));
      end
   end

   task automatic measure_frame();
      int n = 0;
      int trig_cnt = 0;
      int trig_at = -1;
      int fall_at = -1;
      logic prev_cs;
      do @(negedge clk); while (!a_frame);
      prev_cs = a_cs_n;
      do begin
         @(negedge clk);
         n++;
         if (a_trig) begin
            trig_cnt++;
            trig_at = n;
         end
         if (prev_cs && !a_cs_n) fall_at = n;
         prev_cs = a_cs_n;
      end while (!a_frame && n < A_PERIOD + 10);
      chk("R1 strobe spacing", n, A_PERIOD);
      chk("R3 triggers per frame", trig_cnt, 1);
      chk("R3 trigger count value", trig_at, A_TRIG);
      chk("R2 cs fall count value", fall_at, A_CS);
      chk("R7 trigger offset after cs fall", trig_at - fall_at, A_TRIG - A_CS);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R6 cs_n in reset", int'(a_cs_n), 1);
      chk("R6 trigger in reset", int'(a_trig), 0);
      chk("R6 strobe in reset", int'(a_frame), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 cs_n after reset", int'(a_cs_n), 1);
      chk("R6 strobe after reset", int'(a_frame), 0);

      enable = 1'b1;
      @(negedge clk);
      chk("R5 strobe on first enable", int'(a_frame), 1);
      chk("R8 cs_n active at count 0", int'(b_cs_n), 0);

      measure_frame();
      measure_frame();

      // Stop mid-frame while chip-select is active.
      repeat (1000) @(negedge clk);
      chk("R4 precondition cs active", int'(a_cs_n), 0);
      enable = 1'b0;
      @(negedge clk);
      chk("R4 cs_n idle", int'(a_cs_n), 1);
      chk("R4 trigger idle", int'(a_trig), 0);
      chk("R4 strobe idle", int'(a_frame), 0);
      for (int i = 0; i < 800; i++) begin
         @(negedge clk);
         if (a_trig || a_frame || !a_cs_n || !b_cs_n) begin
            chk("R4 outputs stay idle", 0, 1);
         end
      end

      enable = 1'b1;
      @(negedge clk);
      chk("R5 strobe on restart", int'(a_frame), 1);
      chk("R5 cs_n on restart", int'(a_cs_n), 1);

      measure_frame();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule